// File: doc/BRIEF.md
# Carrier-Gated Synchronous Serial Receiver

This block collects a synchronous serial word from a single data line. An external bit clock comes in asynchronously to the system clock. It is brought into the system clock domain through a synchroniser chain, and its transitions are found there by edge detection. Bits arrive least significant first. Each one is taken on the chosen transition of that clock.

A carrier input marks the span of a frame, and its active polarity is a configuration input. In synchronous mode, clock transitions count only while the carrier has already been active for at least one system clock cycle. When the configured number of bits has arrived, the word moves to an output register and a ready flag goes high. If the carrier drops part way through a word, the partial word is thrown away and a framing error is flagged. If a word completes while the previous one is still unread, an overrun is flagged and the new word is lost.

With synchronous mode off, the carrier plays no part. Words are then delimited by the bit count alone.

Top module: `sgr_rx_top`

## Requirements
- R1: After reset the received word is all zeros, and the ready, overrun and framing-error outputs are low.
- R2: Bits are assembled least significant bit first. After WORD_W counted clock edges, the word appears on `rx_word` and `rx_ready` goes high.
- R3: When `sample_rising` is 1, bits are taken on rising edges of `rx_clk_in`. When it is 0, they are taken on falling edges.
- R4: In synchronous mode, edges of `rx_clk_in` that occur while the carrier is inactive are not counted and do not change any output.
- R5: The carrier counts as active when `carrier_in` equals `cd_active_high`: high when that input is 1, low when it is 0.
- R6: An edge that arrives in the same system clock cycle as the carrier becoming active is not counted. The carrier must lead the edge by at least one cycle.
- R7: If the carrier goes inactive after at least one bit of a frame, the partial frame is dropped, `rx_frame_err` goes high and `rx_ready` is not raised. The next full frame is received intact.
- R8: If a frame completes while `rx_ready` is high, `rx_overrun` goes high and `rx_word` keeps the earlier word.
- R9: A one-cycle pulse on `rd_ack` clears `rx_ready`, `rx_overrun` and `rx_frame_err` on the next clock.
- R10: When `sync_mode_en` is 0, the carrier input is ignored. Edges are counted whatever its level, and no framing error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_en | input | 1 | 1 enables carrier gating (synchronous mode) |
| cd_active_high | input | 1 | Active level of the carrier input |
| sample_rising | input | 1 | 1 samples on rising bit-clock edges, 0 on falling |
| rx_clk_in | input | 1 | External bit clock, asynchronous |
| carrier_in | input | 1 | Carrier-detect input, asynchronous |
| rx_data_in | input | 1 | Serial data, asynchronous |
| rd_ack | input | 1 | Read strobe that clears the status flags |
| rx_word | output | WORD_W | Last accepted word |
| rx_ready | output | 1 | A word is waiting to be read |
| rx_overrun | output | 1 | A word was lost because the previous one was unread |
| rx_frame_err | output | 1 | A frame was cut short by the carrier |

## Verification
An edge driven on `rx_clk_in` crosses SYNC_STAGES synchroniser flops and then one edge-detect comparison, so a counted bit is registered on the third rising system clock edge after the pin changes. The word and the ready, overrun and framing-error flags are therefore due three cycles after the last bit edge or the carrier drop. The bench drives the pins on falling clock edges and waits four to six cycles before sampling, also on a falling edge. Flag clearing by `rd_ack` is due on the next rising edge, and the bench checks it two cycles after the pulse.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
   typedef struct packed {
      logic ready;
      logic overrun;
      logic frame_err;
   } sgr_flags_t;

   localparam int SGR_MIN_SYNC = 2;
endpackage

// File: rtl/sgr_sync.sv
module sgr_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import sgr_pkg::*;

   generate
      if (STAGES < SGR_MIN_SYNC) begin : g_bad_stages
         $error("sgr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sgr_sync: W must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sgr_gate.sv
module sgr_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_s,
   input  logic cd_s,
   input  logic sync_en,
   input  logic cd_high,
   input  logic rise_sel,
   output logic bit_stb,
   output logic carrier_off
);
   logic clk_d;
   logic cd_prev;
   logic cd_now;
   logic edge_rise;
   logic edge_fall;
   logic edge_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d   <= 1'b0;
         cd_prev <= 1'b0;
      end else begin
         clk_d   <= clk_s;
         cd_prev <= cd_now;
      end
   end

   always_comb begin
      edge_rise   = clk_s & ~clk_d;
      edge_fall   = ~clk_s & clk_d;
      edge_sel    = rise_sel ? edge_rise : edge_fall;
      cd_now      = sync_en ? (cd_s == cd_high) : 1'b1;
      bit_stb     = edge_sel & cd_now & cd_prev;
      carrier_off = ~cd_now;
   end

   // R4 R6
   carrier_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> $past(cd_now) && !carrier_off);
endmodule

// File: rtl/sgr_assembler.sv
module sgr_assembler #(
   parameter int WORD_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_stb,
   input  logic                  bit_val,
   input  logic                  abort,
   input  logic                  rd_ack,
   output logic [WORD_W-1:0]     word_q,
   output sgr_pkg::sgr_flags_t   flags_q
);
   import sgr_pkg::*;

   localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("sgr_assembler: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] next_word;
   logic              last_bit;
   logic              ready_eff;

   always_comb begin
      next_word = {bit_val, shreg_q[WORD_W-1:1]};
      last_bit  = bit_stb && (cnt_q == LAST);
      ready_eff = flags_q.ready && !rd_ack;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         word_q  <= '0;
         flags_q <= '0;
      end else begin
         if (rd_ack) flags_q <= '0;
         if (abort) begin
            if (cnt_q != '0) flags_q.frame_err <= 1'b1;
            cnt_q <= '0;
         end else if (bit_stb) begin
            shreg_q <= next_word;
            if (last_bit) begin
               cnt_q <= '0;
               if (ready_eff) begin
                  flags_q.overrun <= 1'b1;
               end else begin
                  word_q        <= next_word;
                  flags_q.ready <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && !flags_q.ready) |=> flags_q.ready);
   // R8
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && flags_q.ready && !rd_ack) |=> (flags_q.overrun && $stable(word_q)));
   // R7
   frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && cnt_q != '0) |=> (flags_q.frame_err && cnt_q == '0));
   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !abort && !bit_stb) |=> (flags_q == '0));
endmodule

// File: rtl/sgr_rx_top.sv
module sgr_rx_top #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode_en,
   input  logic              cd_active_high,
   input  logic              sample_rising,
   input  logic              rx_clk_in,
   input  logic              carrier_in,
   input  logic              rx_data_in,
   input  logic              rd_ack,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_ready,
   output logic              rx_overrun,
   output logic              rx_frame_err
);
   import sgr_pkg::*;

   localparam int PIN_W = 3;

   logic [PIN_W-1:0] pins_s;
   logic             bit_stb;
   logic             carrier_off;
   sgr_flags_t       flags;

   sgr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_clk_in, carrier_in, rx_data_in}),
      .q     (pins_s)
   );

   sgr_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_s       (pins_s[2]),
      .cd_s        (pins_s[1]),
      .sync_en     (sync_mode_en),
      .cd_high     (cd_active_high),
      .rise_sel    (sample_rising),
      .bit_stb     (bit_stb),
      .carrier_off (carrier_off)
   );

   sgr_assembler #(.WORD_W(WORD_W)) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .bit_val (pins_s[0]),
      .abort   (carrier_off),
      .rd_ack  (rd_ack),
      .word_q  (rx_word),
      .flags_q (flags)
   );

   assign rx_ready     = flags.ready;
   assign rx_overrun   = flags.overrun;
   assign rx_frame_err = flags.frame_err;

   // R10
   nosync_no_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode_en && !rx_frame_err) |=> !$rose(rx_frame_err));
endmodule

// File: tb/sgr_rx_top_tb.sv
module sgr_rx_top_tb;
   localparam int W  = 8;
   localparam int NV = 6;
   // {sync_en, cd_high, rising, word}
   localparam logic [10:0] VECS [0:NV-1] = '{
      11'b1_1_1_10100101,
      11'b1_1_0_00110110,
      11'b1_0_1_11100001,
      11'b1_0_0_01111110,
      11'b0_1_1_10011001,
      11'b0_0_0_01000010
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_mode_en = 1'b1;
   logic cd_active_high = 1'b1;
   logic sample_rising = 1'b1;
   logic rx_clk_in = 1'b0;
   logic carrier_in = 1'b0;
   logic rx_data_in = 1'b0;
   logic rd_ack = 1'b0;
   logic [W-1:0] rx_word;
   logic rx_ready, rx_overrun, rx_frame_err;

   int checks = 0;
   int fails  = 0;
   logic cur_hi = 1'b1;
   logic cur_rise = 1'b1;
   logic cur_sync = 1'b1;

   always #5 clk = ~clk;

   sgr_rx_top #(.WORD_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_mode_en(sync_mode_en),
      .cd_active_high(cd_active_high), .sample_rising(sample_rising),
      .rx_clk_in(rx_clk_in), .carrier_in(carrier_in), .rx_data_in(rx_data_in),
      .rd_ack(rd_ack), .rx_word(rx_word), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err)
   );

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic setup(input logic sync, input logic hi, input logic rise);
      sync_mode_en = 1'b1;
      carrier_in   = ~cur_hi;
      wcyc(6);
      rx_clk_in = ~rise;
      wcyc(6);
      cd_active_high = hi;
      carrier_in     = ~hi;
      wcyc(6);
      sample_rising = rise;
      sync_mode_en  = sync;
      cur_hi = hi; cur_rise = rise; cur_sync = sync;
      wcyc(6);
   endtask

   task automatic send_bits(input logic [W-1:0] word, input int n);
      for (int i = 0; i < n; i++) begin
         rx_data_in = word[i];
         rx_clk_in  = ~cur_rise;
         wcyc(4);
         rx_clk_in  = cur_rise;
         wcyc(4);
      end
      rx_clk_in = ~cur_rise;
   endtask

   task automatic frame(input logic [W-1:0] word);
      if (cur_sync) carrier_in = cur_hi;
      wcyc(4);
      send_bits(word, W);
      wcyc(4);
      carrier_in = ~cur_hi;
      wcyc(6);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      wcyc(1);
      rd_ack = 1'b0;
      wcyc(2);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      wcyc(200000 - 10);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wcyc(4);
      // R1 reset state
      check("R1 word", 32'(rx_word), 32'h0);
      check("R1 ready", 32'(rx_ready), 32'h0);
      rst_n = 1'b1;
      wcyc(4);
      check("R1 overrun", 32'(rx_overrun), 32'h0);
      check("R1 frame_err", 32'(rx_frame_err), 32'h0);

      // R2 R3 R5 R10 table walk
      for (int v = 0; v < NV; v++) begin
         setup(VECS[v][10], VECS[v][9], VECS[v][8]);
         frame(VECS[v][7:0]);
         check("R2 R3 R5 R10 word", 32'(rx_word), 32'(VECS[v][7:0]));
         check("R2 ready", 32'(rx_ready), 32'h1);
         check("R10 no frame_err", 32'(rx_frame_err), 32'h0);
         ack();
         check("R9 ready cleared", 32'(rx_ready), 32'h0);
      end

      // R4 edges while carrier inactive are ignored
      setup(1'b1, 1'b1, 1'b1);
      send_bits(8'hFF, 5);
      wcyc(6);
      check("R4 ready after gated edges", 32'(rx_ready), 32'h0);
      frame(8'h00);
      check("R4 word", 32'(rx_word), 32'h00);
      check("R4 frame_err", 32'(rx_frame_err), 32'h0);
      ack();

      // R6 edge coincident with carrier rising is not counted
      rx_data_in = 1'b1;
      carrier_in = 1'b1;
      rx_clk_in  = 1'b1;
      wcyc(4);
      rx_clk_in  = 1'b0;
      wcyc(4);
      send_bits(8'h00, W);
      wcyc(4);
      carrier_in = 1'b0;
      wcyc(6);
      check("R6 word", 32'(rx_word), 32'h00);
      check("R6 frame_err", 32'(rx_frame_err), 32'h0);
      ack();

      // R8 overrun keeps earlier word
      frame(8'h3C);
      frame(8'hC3);
      check("R8 overrun", 32'(rx_overrun), 32'h1);
      check("R8 word kept", 32'(rx_word), 32'h3C);
      check("R8 ready", 32'(rx_ready), 32'h1);
      ack();
      check("R9 overrun cleared", 32'(rx_overrun), 32'h0);

      // R7 carrier drop mid-frame
      carrier_in = 1'b1;
      wcyc(4);
      send_bits(8'hFF, 3);
      wcyc(2);
      carrier_in = 1'b0;
      wcyc(6);
      check("R7 frame_err", 32'(rx_frame_err), 32'h1);
      check("R7 ready", 32'(rx_ready), 32'h0);
      ack();
      check("R9 frame_err cleared", 32'(rx_frame_err), 32'h0);
      frame(8'h5A);
      check("R7 next frame intact", 32'(rx_word), 32'h5A);
      ack();

      finish_run();
   end
endmodule